// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps in-flight instructions in program order so that an out-of-order core can finish work in any order but still update architectural state in sequence. Dispatch claims a slot at the tail and receives its index. Execution units later write a result and a fault flag into that slot by index, in whatever order they finish. The oldest slot leaves through a single commit port to the register file only when it is complete and fault-free. Nothing reaches architectural state before commit, so recovery never has to undo a register write.

Two recovery paths are provided. A mispredicted branch names its own slot; every younger slot is dropped, while the branch and everything older stay. A completed head slot whose fault flag is set does not commit. Instead the block raises a fault report carrying that slot's PC and empties itself.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready_o` is 1, `alloc_idx_o` is 0, and `commit_valid_o` and `exc_valid_o` are 0.
- R2: An accepted allocation writes the tag and PC into the slot given by `alloc_idx_o`. Successive accepted allocations receive indices that increase by one modulo DEPTH.
- R3: `alloc_ready_o` is 0 when DEPTH slots are live, unless the head commits in that cycle. In that case the freed slot may be claimed in the same cycle.
- R4: A writeback sets the completion bit of the named live slot and stores its data and fault flag. Writebacks may arrive in any order.
- R5: `commit_valid_o` is 1 only when the oldest live slot is complete with its fault flag clear. Commits occur strictly oldest first, one per cycle, and carry that slot's tag and data.
- R6: A branch flush naming slot b keeps b and all older slots. The next allocation then receives index (b+1) mod DEPTH.
- R7: In a branch-flush cycle, or while a fault is reported, `alloc_ready_o` is 0 and any writeback is ignored. A writeback to a slot that is not live is always ignored.
- R8: When the oldest live slot is complete with its fault flag set, `exc_valid_o` is 1 with `exc_pc_o` equal to its PC, and it does not commit. In the next cycle the buffer is empty, and the next allocation receives the index of the faulting slot.
- R9: One allocation, one writeback and one commit may all take effect in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Dispatch requests a slot |
| alloc_tag_i | input | TAG_W | Destination register tag |
| alloc_pc_i | input | PC_W | Instruction PC |
| alloc_ready_o | output | 1 | Slot available this cycle |
| alloc_idx_o | output | $clog2(DEPTH) | Index of the slot being allocated |
| wb_valid_i | input | 1 | Execution result valid |
| wb_idx_i | input | $clog2(DEPTH) | Target slot of result |
| wb_data_i | input | DATA_W | Result value |
| wb_exc_i | input | 1 | Result carries a fault |
| bflush_valid_i | input | 1 | Branch mispredicted |
| bflush_idx_i | input | $clog2(DEPTH) | Slot of the mispredicted branch |
| commit_valid_o | output | 1 | Register file write this cycle |
| commit_tag_o | output | TAG_W | Destination tag being committed |
| commit_data_o | output | DATA_W | Value being committed |
| exc_valid_o | output | 1 | Precise fault reported |
| exc_pc_o | output | PC_W | PC of faulting instruction |

## Verification
The bench builds the block with DEPTH=4, 3-bit tags and 8-bit data and PC. With that depth, both pointers wrap many times in a short run. It also makes an exhaustive sweep possible: the branch position and the fault position are each placed at every slot of a full buffer. A long mixed stream, with allocation on every cycle and writebacks to rotating indices, hits the full-and-retire case, writebacks to dead slots and mid-stream faults. A cycle model in the bench predicts every output.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    HEAD_WAIT   = 2'd0,
    HEAD_COMMIT = 2'd1,
    HEAD_FAULT  = 2'd2
  } head_act_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
// Head/tail pointers with wrap bit; DEPTH must be a power of two.
module rob_ptr_ctrl #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             retire_i,
  input  logic             fault_i,
  input  logic             bflush_i,
  input  logic [IDX_W-1:0] bflush_idx_i,
  input  logic [IDX_W-1:0] wb_idx_i,
  output logic [IDX_W-1:0] head_idx_o,
  output logic [IDX_W-1:0] tail_idx_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             wb_live_o
);
  logic [PTR_W-1:0] head_q, tail_q, head_d, tail_d, count;
  logic [IDX_W-1:0] bf_off, wb_off;

  assign count      = tail_q - head_q;
  assign empty_o    = (count == '0);
  assign full_o     = (count == PTR_W'(DEPTH));
  assign head_idx_o = head_q[IDX_W-1:0];
  assign tail_idx_o = tail_q[IDX_W-1:0];
  assign bf_off     = bflush_idx_i - head_q[IDX_W-1:0];
  assign wb_off     = wb_idx_i - head_q[IDX_W-1:0];
  assign wb_live_o  = ({1'b0, wb_off} < count);

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    if (fault_i) begin
      tail_d = head_q;  // drop head and everything younger
    end else begin
      if (retire_i) head_d = head_q + 1'b1;
      if (bflush_i)     tail_d = head_q + {1'b0, bf_off} + 1'b1;
      else if (alloc_i) tail_d = tail_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= PTR_W'(DEPTH)); // R3
  AST_RETIRE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i && !fault_i |=> head_q == $past(head_q) + 1'b1); // R5
  AST_FAULT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> (head_q == tail_q) && (head_q == $past(head_q))); // R8
  AST_BFLUSH_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bflush_i && !fault_i |=> tail_q[IDX_W-1:0] == IDX_W'($past(bflush_idx_i) + 1'b1)); // R6
endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store #(
  parameter int DEPTH  = 16,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [IDX_W-1:0]  alloc_idx_i,
  input  logic [TAG_W-1:0]  alloc_tag_i,
  input  logic [PC_W-1:0]   alloc_pc_i,
  input  logic              wb_i,
  input  logic [IDX_W-1:0]  wb_idx_i,
  input  logic [DATA_W-1:0] wb_data_i,
  input  logic              wb_exc_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_done_o,
  output logic              rd_exc_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [PC_W-1:0]   rd_pc_o
);
  logic [DEPTH-1:0]  done_q, exc_q;
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PC_W-1:0]   pc_q   [DEPTH];

  // Allocation wins over a same-slot writeback (slot freed and reused).
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= '0;
      exc_q  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_i && alloc_idx_i == IDX_W'(i)) begin
          done_q[i] <= 1'b0;
          exc_q[i]  <= 1'b0;
        end else if (wb_i && wb_idx_i == IDX_W'(i)) begin
          done_q[i] <= 1'b1;
          exc_q[i]  <= wb_exc_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc_i && alloc_idx_i == IDX_W'(i)) begin
        tag_q[i] <= alloc_tag_i;
        pc_q[i]  <= alloc_pc_i;
      end else if (wb_i && wb_idx_i == IDX_W'(i)) begin
        data_q[i] <= wb_data_i;
      end
    end
  end

  assign rd_done_o = done_q[rd_idx_i];
  assign rd_exc_o  = exc_q[rd_idx_i];
  assign rd_tag_o  = tag_q[rd_idx_i];
  assign rd_data_o = data_q[rd_idx_i];
  assign rd_pc_o   = pc_q[rd_idx_i];

  AST_WB_SETS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_i && !(alloc_i && alloc_idx_i == wb_idx_i) |=> done_q[$past(wb_idx_i)]); // R4
  AST_ALLOC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |=> !done_q[$past(alloc_idx_i)]); // R2
endmodule

// File: rtl/rob_core.sv
module rob_core #(
  parameter int DEPTH  = 16,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic [TAG_W-1:0]  alloc_tag_i,
  input  logic [PC_W-1:0]   alloc_pc_i,
  output logic              alloc_ready_o,
  output logic [IDX_W-1:0]  alloc_idx_o,
  input  logic              wb_valid_i,
  input  logic [IDX_W-1:0]  wb_idx_i,
  input  logic [DATA_W-1:0] wb_data_i,
  input  logic              wb_exc_i,
  input  logic              bflush_valid_i,
  input  logic [IDX_W-1:0]  bflush_idx_i,
  output logic              commit_valid_o,
  output logic [TAG_W-1:0]  commit_tag_o,
  output logic [DATA_W-1:0] commit_data_o,
  output logic              exc_valid_o,
  output logic [PC_W-1:0]   exc_pc_o
);
  import rob_pkg::*;

  logic [IDX_W-1:0] head_idx, tail_idx;
  logic empty, full, wb_live, hd_done, hd_exc;
  logic retire, fault, alloc_go, wb_go, bflush_go;
  head_act_e act;

  always_comb begin
    act = HEAD_WAIT;
    if (!empty && hd_done) act = hd_exc ? HEAD_FAULT : HEAD_COMMIT;
  end

  assign retire        = (act == HEAD_COMMIT);
  assign fault         = (act == HEAD_FAULT);
  assign alloc_ready_o = (!full || retire) && !bflush_valid_i && !fault;
  assign alloc_go      = alloc_valid_i && alloc_ready_o;
  assign bflush_go     = bflush_valid_i && !fault;
  assign wb_go         = wb_valid_i && wb_live && !bflush_valid_i && !fault;
  assign alloc_idx_o   = tail_idx;
  assign commit_valid_o = retire;
  assign exc_valid_o    = fault;

  rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk_i, .rst_ni,
    .alloc_i      (alloc_go),
    .retire_i     (retire),
    .fault_i      (fault),
    .bflush_i     (bflush_go),
    .bflush_idx_i (bflush_idx_i),
    .wb_idx_i     (wb_idx_i),
    .head_idx_o   (head_idx),
    .tail_idx_o   (tail_idx),
    .empty_o      (empty),
    .full_o       (full),
    .wb_live_o    (wb_live)
  );

  rob_entry_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W), .PC_W(PC_W)) u_store (
    .clk_i, .rst_ni,
    .alloc_i     (alloc_go),
    .alloc_idx_i (tail_idx),
    .alloc_tag_i (alloc_tag_i),
    .alloc_pc_i  (alloc_pc_i),
    .wb_i        (wb_go),
    .wb_idx_i    (wb_idx_i),
    .wb_data_i   (wb_data_i),
    .wb_exc_i    (wb_exc_i),
    .rd_idx_i    (head_idx),
    .rd_done_o   (hd_done),
    .rd_exc_o    (hd_exc),
    .rd_tag_o    (commit_tag_o),
    .rd_data_o   (commit_data_o),
    .rd_pc_o     (exc_pc_o)
  );

  AST_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full && !commit_valid_o |-> !alloc_ready_o); // R3
  AST_ONE_HEAD_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_valid_o && exc_valid_o)); // R8
  AST_FLUSH_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bflush_valid_i |-> !alloc_ready_o); // R7
endmodule

// File: tb/sim_rob_core.sv
module sim_rob_core;
  localparam int D = 4, TW = 3, DW = 8, PW = 8, IW = 2;

  logic clk_i = 0, rst_ni = 0;
  logic alloc_valid_i = 0, wb_valid_i = 0, wb_exc_i = 0, bflush_valid_i = 0;
  logic [TW-1:0] alloc_tag_i = 0;
  logic [PW-1:0] alloc_pc_i = 0;
  logic [IW-1:0] wb_idx_i = 0, bflush_idx_i = 0;
  logic [DW-1:0] wb_data_i = 0;
  logic alloc_ready_o, commit_valid_o, exc_valid_o;
  logic [IW-1:0] alloc_idx_o;
  logic [TW-1:0] commit_tag_o;
  logic [DW-1:0] commit_data_o;
  logic [PW-1:0] exc_pc_o;

  int n_chk = 0, n_fail = 0;
  int m_head = 0, m_cnt = 0;
  logic [TW-1:0] m_tag [D];
  logic [PW-1:0] m_pc [D];
  logic [DW-1:0] m_data [D];
  logic m_done [D], m_exc [D];

  always #5 clk_i = ~clk_i;

  rob_core #(.DEPTH(D), .TAG_W(TW), .DATA_W(DW), .PC_W(PW)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    alloc_valid_i = 0; wb_valid_i = 0; bflush_valid_i = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    m_head = 0; m_cnt = 0;
    for (int i = 0; i < D; i++) m_done[i] = 0;
  endtask

  // One cycle: drive at negedge, check outputs against model, update model at posedge.
  task automatic cyc(input bit av, input int tag, input int pc,
                     input bit wv, input int wi, input int wd, input bit we,
                     input bit bv, input int bi);
    int h, slot, nc;
    bit hd, flt, ret, rdy;
    @(negedge clk_i);
    alloc_valid_i = av; alloc_tag_i = TW'(tag); alloc_pc_i = PW'(pc);
    wb_valid_i = wv; wb_idx_i = IW'(wi); wb_data_i = DW'(wd); wb_exc_i = we;
    bflush_valid_i = bv; bflush_idx_i = IW'(bi);
    h   = m_head;
    hd  = (m_cnt > 0) && m_done[h];
    flt = hd && m_exc[h];
    ret = hd && !m_exc[h];
    rdy = (m_cnt < D || ret) && !bv && !flt;
    #1;
    chk(alloc_ready_o == rdy, "R3/R7 alloc_ready", alloc_ready_o, rdy);
    chk(alloc_idx_o == IW'((m_head + m_cnt) % D), "R2/R6 alloc_idx", alloc_idx_o, (m_head + m_cnt) % D);
    chk(commit_valid_o == ret, "R5 commit_valid", commit_valid_o, ret);
    if (ret) begin
      chk(commit_tag_o == m_tag[h], "R5 commit_tag", commit_tag_o, m_tag[h]);
      chk(commit_data_o == m_data[h], "R5 commit_data", commit_data_o, m_data[h]);
    end
    chk(exc_valid_o == flt, "R8 exc_valid", exc_valid_o, flt);
    if (flt) chk(exc_pc_o == m_pc[h], "R8 exc_pc", exc_pc_o, m_pc[h]);
    @(posedge clk_i);
    if (flt) m_cnt = 0;
    else begin
      nc = m_cnt;
      if (bv) nc = (bi + D - m_head) % D + 1;
      else if (wv && ((wi + D - m_head) % D) < m_cnt) begin
        m_done[wi] = 1; m_data[wi] = DW'(wd); m_exc[wi] = we;
      end
      if (av && rdy) begin
        slot = (m_head + m_cnt) % D;
        m_tag[slot] = TW'(tag); m_pc[slot] = PW'(pc); m_done[slot] = 0;
        nc++;
      end
      if (ret) begin m_head = (m_head + 1) % D; nc--; end
      m_cnt = nc;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    #1;
    chk(alloc_ready_o == 1 && alloc_idx_o == 0, "R1 reset ready/idx", alloc_idx_o, 0);
    chk(!commit_valid_o && !exc_valid_o, "R1 reset idle", commit_valid_o, 0);
    // R2/R3: fill, then try allocating while full
    for (int i = 0; i < D; i++) cyc(1, i + 1, 16 + i, 0, 0, 0, 0, 0, 0);
    cyc(1, 7, 99, 0, 0, 0, 0, 0, 0);
    // R4/R5: out-of-order completion, head last
    cyc(0, 0, 0, 1, 2, 8'hA2, 0, 0, 0);
    cyc(0, 0, 0, 1, 1, 8'hA1, 0, 0, 0);
    cyc(0, 0, 0, 1, 3, 8'hA3, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 8'hA0, 0, 0, 0);
    idle(6);
    // R9/R7: mixed stream, alloc every cycle, rotating writebacks, occasional faults
    for (int c = 0; c < 400; c++)
      cyc(1, c % 8, c, 1, (c * 3) % D, (c * 17) % 256, (c % 23) == 11, 0, 0);
    idle(6);
    // R6/R7: branch at each position of a full buffer
    for (int k = 0; k < D; k++) begin
      do_reset();
      for (int i = 0; i < D; i++) cyc(1, i + 2, 32 + i, 0, 0, 0, 0, 0, 0);
      cyc(1, 5, 77, 1, 0, 8'h55, 0, 1, k);  // alloc and writeback dropped
      for (int i = 0; i < D; i++) cyc(0, 0, 0, 1, i, 8'h60 + i, 0, 0, 0);
      idle(6);
      cyc(1, 6, 88, 0, 0, 0, 0, 0, 0);  // next index is (k+1) mod D
    end
    // R8: fault at each position, plus wraparound via a shifted head
    for (int f = 0; f < D; f++) begin
      do_reset();
      cyc(1, 1, 40, 0, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 1, 0, 8'h11, 0, 0, 0);
      for (int i = 0; i < D; i++) cyc(1, i + 1, 48 + i, 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < D; i++)
        cyc(0, 0, 0, 1, (1 + i) % D, 8'h70 + i, i == f, 0, 0);
      idle(6);
      cyc(1, 3, 90, 0, 0, 0, 0, 0, 0);
      idle(2);
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule